// File: doc/BRIEF.md
# Paged Address Translator with Presence

This block maps a virtual word address onto a physical word address in a paged memory system. The virtual address has two fields. The upper field is the page number and the lower field is the line, meaning the word within the page. The page number selects one entry of an internal mapping table. Each entry holds a physical block number and a presence flag. On a successful lookup, the physical address is the stored block number placed above the unchanged line field. The physical memory is smaller than the virtual space, so the block field is narrower than the page field.

If the selected entry is not present, the block raises a page-fault indication in place of an address. The software managing memory loads the table through a separate write port. Each write sets the block number and sets or clears the presence flag of one entry. Lookups are registered: the response appears one clock after the request. In the default configuration the virtual space is 8K words and the physical space is 4K words, both in 1K-word pages. The same RTL also builds with a 20-bit virtual address and a 15-bit physical address.

Top module: `page_translator`

## Requirements
- R1: After reset, every table entry is absent, so any lookup made before the first table write returns a fault, and `rspValid`, `rspFault` and `rspPaddr` are all 0.
- R2: A request accepted at a clock edge (`reqValid`=1) produces exactly one response, with `rspValid`=1 in the following cycle. A cycle with `reqValid`=0 produces `rspValid`=0 in the following cycle.
- R3: A lookup of a present entry returns `rspFault`=0 and `rspPaddr` = {stored block, line}. The line is bits [LINE_W-1:0] of the virtual address, copied unchanged into the low bits, and the block occupies bits [PA_W-1:LINE_W].
- R4: A lookup of an entry whose presence flag is 0 returns `rspFault`=1 with `rspPaddr` equal to 0.
- R5: A table write (`wrEn`=1) stores `wrBlock` and `wrPresent` into the entry `wrPage`. Writing `wrPresent`=0 to a loaded entry makes later lookups of that page fault.
- R6: When a write and a lookup hit the same entry at the same edge, the response reflects the entry's contents from before the write. The new contents are seen from the next lookup onward.
- R7: `rspFault` is 1 only together with `rspValid`. While `rspValid`=0, `rspPaddr` and `rspFault` are 0.
- R8: A write to one entry leaves every other entry's block and presence unchanged.
- R9: With VA_W=20, PA_W=15 and LINE_W=10, the block translates a 10-bit page number to a 5-bit block number under the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Lookup request strobe |
| reqVaddr | input | VA_W | Virtual word address to translate |
| wrEn | input | 1 | Table write strobe |
| wrPage | input | VA_W-LINE_W | Entry (page number) being written |
| wrBlock | input | PA_W-LINE_W | Physical block number to store |
| wrPresent | input | 1 | Presence flag to store |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspPaddr | output | PA_W | Physical word address, 0 on a fault |
| rspFault | output | 1 | Page fault: the entry was not present |

## Verification
The first pattern sweeps every page straight after reset, before any write. This shows whether presence truly starts cleared in all entries (R1). The bench then loads a sparse map with distinct block numbers and interleaves present and absent pages with varied line values, back to back. This shows whether the block and line fields are placed correctly and whether faults are reported per page rather than per block (R3, R4). Writes that coincide with lookups of the same page, and clear-after-set sequences, show whether the old contents are returned in the write cycle and whether presence can be withdrawn (R5, R6). A second, wide instance checks the 20-to-15-bit configuration with a high page number (R9).

// File: rtl/pt_pkg.sv
package pt_pkg;
  // Strobes passed from control to datapath for one cycle
  typedef struct packed {
    logic lookup;
    logic tableWr;
  } ctrlStrobes_t;
endpackage

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
(
  input  logic         reqValid,
  input  logic         wrEn,
  output ctrlStrobes_t strobes
);
  // Lookups and writes are independent; both may occur in the same cycle.
  always_comb begin
    strobes.lookup  = reqValid;
    strobes.tableWr = wrEn;
  end
endmodule

// File: rtl/pt_datapath.sv
module pt_datapath
  import pt_pkg::*;
#(
  parameter int VA_W   = 13,
  parameter int PA_W   = 12,
  parameter int LINE_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic [VA_W-1:0]          reqVaddr,
  input  logic [VA_W-LINE_W-1:0]   wrPage,
  input  logic [PA_W-LINE_W-1:0]   wrBlock,
  input  logic                     wrPresent,
  output logic                     rspValid,
  output logic [PA_W-1:0]          rspPaddr,
  output logic                     rspFault
);
  localparam int PAGE_W  = VA_W - LINE_W;
  localparam int BLK_W   = PA_W - LINE_W;
  localparam int ENTRIES = 1 << PAGE_W;

  logic [ENTRIES-1:0] presentQ;
  logic [BLK_W-1:0]   blockQ [ENTRIES];
  logic [ENTRIES-1:0] entryWr;

  // One write-enable per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_wrDecode
    assign entryWr[g] = strobes.tableWr && (wrPage == PAGE_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        presentQ[i] <= 1'b0;
        blockQ[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (entryWr[i]) begin
          presentQ[i] <= wrPresent;
          blockQ[i]   <= wrBlock;
        end
      end
    end
  end

  // Lookup reads the table before this edge's write lands (old contents)
  logic [PAGE_W-1:0] lookPage;
  logic [LINE_W-1:0] lookLine;
  logic              lookPresent;
  logic [BLK_W-1:0]  lookBlock;

  always_comb begin
    lookPage    = reqVaddr[VA_W-1:LINE_W];
    lookLine    = reqVaddr[LINE_W-1:0];
    lookPresent = presentQ[lookPage];
    lookBlock   = blockQ[lookPage];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspPaddr <= '0;
    end else begin
      rspValid <= strobes.lookup;
      rspFault <= strobes.lookup && !lookPresent;
      rspPaddr <= (strobes.lookup && lookPresent) ? {lookBlock, lookLine} : '0;
    end
  end
endmodule

// File: rtl/page_translator.sv
module page_translator
  import pt_pkg::*;
#(
  parameter int VA_W   = 13,
  parameter int PA_W   = 12,
  parameter int LINE_W = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [VA_W-1:0]        reqVaddr,
  input  logic                   wrEn,
  input  logic [VA_W-LINE_W-1:0] wrPage,
  input  logic [PA_W-LINE_W-1:0] wrBlock,
  input  logic                   wrPresent,
  output logic                   rspValid,
  output logic [PA_W-1:0]        rspPaddr,
  output logic                   rspFault
);
  ctrlStrobes_t strobes;

  pt_ctrl i_ctrl (
    .reqValid (reqValid),
    .wrEn     (wrEn),
    .strobes  (strobes)
  );

  pt_datapath #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .LINE_W (LINE_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqVaddr  (reqVaddr),
    .wrPage    (wrPage),
    .wrBlock   (wrBlock),
    .wrPresent (wrPresent),
    .rspValid  (rspValid),
    .rspPaddr  (rspPaddr),
    .rspFault  (rspFault)
  );
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int VA_W   = 13,
  parameter int PA_W   = 12,
  parameter int LINE_W = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [VA_W-1:0] reqVaddr,
  input logic            rspValid,
  input logic [PA_W-1:0] rspPaddr,
  input logic            rspFault
);
  AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R2
  AST_IDLE_GIVES_NO_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R2
  AST_LINE_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspFault || rspPaddr[LINE_W-1:0] == $past(reqVaddr[LINE_W-1:0]))); // R3
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspPaddr == '0)); // R4
  AST_FAULT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspValid); // R7
  AST_IDLE_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspPaddr == '0)); // R7
endmodule

bind page_translator pt_checker #(
  .VA_W   (VA_W),
  .PA_W   (PA_W),
  .LINE_W (LINE_W)
) i_pt_checker (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqVaddr (reqVaddr),
  .rspValid (rspValid),
  .rspPaddr (rspPaddr),
  .rspFault (rspFault)
);

// File: tb/test_page_translator.sv
`timescale 1ns/1ps
module test_page_translator;
  localparam int VA_W = 13, PA_W = 12, LINE_W = 10;
  localparam int PAGE_W = VA_W - LINE_W, BLK_W = PA_W - LINE_W;
  localparam int ENTRIES = 1 << PAGE_W;
  localparam int WVA = 20, WPA = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic reqValid = 0, wrEn = 0, wrPresent = 0;
  logic [VA_W-1:0] reqVaddr = '0;
  logic [PAGE_W-1:0] wrPage = '0;
  logic [BLK_W-1:0] wrBlock = '0;
  logic rspValid, rspFault;
  logic [PA_W-1:0] rspPaddr;

  page_translator #(.VA_W(VA_W), .PA_W(PA_W), .LINE_W(LINE_W)) i_page_translator (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .wrEn(wrEn), .wrPage(wrPage), .wrBlock(wrBlock), .wrPresent(wrPresent),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault));

  // Wide configuration
  logic wReqValid = 0, wWrEn = 0, wWrPresent = 0;
  logic [WVA-1:0] wReqVaddr = '0;
  logic [WVA-LINE_W-1:0] wWrPage = '0;
  logic [WPA-LINE_W-1:0] wWrBlock = '0;
  logic wRspValid, wRspFault;
  logic [WPA-1:0] wRspPaddr;

  page_translator #(.VA_W(WVA), .PA_W(WPA), .LINE_W(LINE_W)) i_page_translator_w (
    .clk(clk), .rstN(rstN), .reqValid(wReqValid), .reqVaddr(wReqVaddr),
    .wrEn(wWrEn), .wrPage(wWrPage), .wrBlock(wWrBlock), .wrPresent(wWrPresent),
    .rspValid(wRspValid), .rspPaddr(wRspPaddr), .rspFault(wRspFault));

  int total = 0, bad = 0;

  typedef struct {
    logic            fault;
    logic [PA_W-1:0] paddr;
    string           tag;
  } expItem_t;
  expItem_t expQ[$];

  // Bench model of the table
  logic             mPresent [ENTRIES];
  logic [BLK_W-1:0] mBlock   [ENTRIES];

  task automatic check(input bit ok, input string tag, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // Driver: one cycle, optional lookup and optional write
  task automatic step(input bit doReq, input logic [VA_W-1:0] va,
                      input bit doWr, input logic [PAGE_W-1:0] pg,
                      input logic [BLK_W-1:0] blk, input logic pres,
                      input string tag);
    expItem_t e;
    if (doReq) begin
      logic [PAGE_W-1:0] p;
      p = va[VA_W-1:LINE_W];
      e.fault = !mPresent[p];
      e.paddr = mPresent[p] ? {mBlock[p], va[LINE_W-1:0]} : '0;
      e.tag   = tag;
      expQ.push_back(e);   // expectation uses contents before this write (R6)
    end
    reqValid = doReq; reqVaddr = va;
    wrEn = doWr; wrPage = pg; wrBlock = blk; wrPresent = pres;
    @(posedge clk); #1;
    if (doWr) begin
      mPresent[pg] = pres;
      mBlock[pg]   = blk;
    end
    reqValid = 0; wrEn = 0;
  endtask

  task automatic lookup(input logic [VA_W-1:0] va, input string tag);
    step(1, va, 0, '0, '0, 0, tag);
  endtask

  task automatic load(input logic [PAGE_W-1:0] pg, input logic [BLK_W-1:0] blk,
                      input logic pres);
    step(0, '0, 1, pg, blk, pres, "R5");
  endtask

  // Monitor: compares responses against the queue
  bit monOn = 0;
  always @(negedge clk) begin
    if (monOn) begin
      if (rspValid) begin
        if (expQ.size() == 0) begin
          check(0, "R2", "unexpected response");
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(rspFault == e.fault && rspPaddr == e.paddr, e.tag,
                $sformatf("paddr=%h fault=%b expected paddr=%h fault=%b",
                          rspPaddr, rspFault, e.paddr, e.fault));
        end
      end else begin
        check(rspFault == 0 && rspPaddr == '0, "R7",
              $sformatf("idle paddr=%h fault=%b expected paddr=0 fault=0",
                        rspPaddr, rspFault));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      mPresent[i] = 0;
      mBlock[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    check(rspValid == 0 && rspFault == 0 && rspPaddr == '0, "R1",
          $sformatf("in reset valid=%b fault=%b paddr=%h expected 0 0 0",
                    rspValid, rspFault, rspPaddr));
    rstN = 1;
    @(posedge clk); #1;
    monOn = 1;

    // R1: all pages fault before any write
    for (int p = 0; p < ENTRIES; p++)
      lookup({PAGE_W'(p), LINE_W'(p * 37 + 5)}, "R1");

    // R5: load a sparse map
    load(3'd5, 2'd1, 1);
    load(3'd2, 2'd3, 1);
    load(3'd0, 2'd2, 1);
    load(3'd7, 2'd0, 1);

    // R3 / R4: present and absent pages interleaved, back to back
    lookup({3'd5, 10'h153}, "R3");
    lookup({3'd1, 10'h3FF}, "R4");
    lookup({3'd2, 10'h000}, "R3");
    lookup({3'd0, 10'h2AA}, "R3");
    lookup({3'd6, 10'h001}, "R4");
    lookup({3'd7, 10'h3FF}, "R3");

    // R8: rewriting page 2 leaves pages 5 and 0 intact
    load(3'd2, 2'd0, 1);
    lookup({3'd5, 10'h011}, "R8");
    lookup({3'd0, 10'h022}, "R8");
    lookup({3'd2, 10'h033}, "R5");

    // R6: write and lookup of the same page at the same edge
    step(1, {3'd5, 10'h0F0}, 1, 3'd5, 2'd3, 1, "R6");
    lookup({3'd5, 10'h0F0}, "R6");
    step(1, {3'd4, 10'h100}, 1, 3'd4, 2'd2, 1, "R6");   // absent -> fault
    lookup({3'd4, 10'h100}, "R6");

    // R5: clearing presence makes the page fault
    load(3'd7, 2'd0, 0);
    lookup({3'd7, 10'h055}, "R5");

    // R2: idle gaps between requests
    repeat (3) @(posedge clk);
    #1;
    lookup({3'd0, 10'h1C3}, "R2");
    repeat (2) @(posedge clk);
    #1;
    check(expQ.size() == 0, "R2",
          $sformatf("pending=%0d expected 0", expQ.size()));
    monOn = 0;

    // R9: wide configuration
    wWrEn = 1; wWrPage = 10'd700; wWrBlock = 5'd19; wWrPresent = 1;
    @(posedge clk); #1;
    wWrEn = 0;
    wReqValid = 1; wReqVaddr = {10'd700, 10'h2B7};
    @(posedge clk); #1;
    wReqValid = 1; wReqVaddr = {10'd701, 10'h2B7};
    @(negedge clk);
    check(wRspValid && !wRspFault && wRspPaddr == {5'd19, 10'h2B7}, "R9",
          $sformatf("paddr=%h fault=%b expected paddr=%h fault=0",
                    wRspPaddr, wRspFault, {5'd19, 10'h2B7}));
    @(posedge clk); #1;
    wReqValid = 0;
    @(negedge clk);
    check(wRspValid && wRspFault && wRspPaddr == '0, "R9",
          $sformatf("paddr=%h fault=%b expected paddr=0 fault=1",
                    wRspPaddr, wRspFault));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule